// File: doc/BRIEF.md
# Multiport distributed LUT RAM

This block is a small bit-organised memory built from a group of 64-entry, 1-bit storage cells. Each cell takes one write on the rising clock edge and reads without a clock. A single mode parameter sets how the cells are wired. The block can act as one deeper single-port memory (64, 128 or 256 entries). It can also be a 64-entry memory with extra read-only ports: two ports in total, or four. The last choice is a 64-entry memory three bits wide, with one address for writing and a separate address for reading.

In the single-port modes the low six address bits index inside a cell. The upper bits pick the cell that takes the write, and the same bits pick the cell that drives the output. In the multi-port modes every cell takes every write, so each cell holds a full copy and serves one read port. In the three-bit mode each cell stores one bit of the word. A read is combinational, so a read at the address being written shows the old value up to the clock edge and the new value after it.

Top module: `lutram_multiport`

## Requirements
- R1: At power-up every location reads as zero on every read port; the block has no reset input.
- R2: When `wr_en` is 1 at a rising clock edge, the word at `rw_addr` is replaced by `wr_data`. Every other location keeps its value.
- R3: When `wr_en` is 0 at a rising edge, the stored contents do not change, whatever `wr_data` holds.
- R4: Reads are combinational. During a write cycle, a read at the written address shows the old value before the edge and the new value after it.
- R5: In the 128- and 256-entry single-port modes, `rw_addr` bits above bit 5 select the cell that is written and the cell that is read. All 2^AW locations are independent.
- R6: In dual-port mode, `x_rdata[0]` reads the shared contents at `ra_addr[5:0]`, while `a_rdata` reads at `rw_addr`.
- R7: In quad-port mode, read-only port k (k = 0..2) reads at `ra_addr[6k+5:6k]` onto `x_rdata[k]`. All four ports see the same 64-entry contents.
- R8: In the 64x3 simple-dual-port mode, `rw_addr` is used only for writing. The 3-bit word at `ra_addr[5:0]` appears on `x_rdata[2:0]`, and `a_rdata` is held at zero.
- R9: In the single-port modes, `x_rdata` is held at zero and `ra_addr` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| wr_en | input | 1 | Write enable sampled at the rising edge |
| rw_addr | input | AW (6, 7 or 8 by mode) | Read/write address of port A; write-only address in the 3-bit mode |
| wr_data | input | DW (3 in the 3-bit mode, else 1) | Data written at the edge |
| ra_addr | input | 6 x max(1, read-only ports) | Packed 6-bit addresses of the read-only ports |
| a_rdata | output | DW | Combinational read at `rw_addr` (zero in the 3-bit mode) |
| x_rdata | output | DW x max(1, read-only ports) | Combinational outputs of the read-only ports |

## Verification
Suppose a write is steered to the wrong cell, or goes missing from one copy. The fault then appears on the first read of that address from the affected port, in the same cycle the address is applied, because no register stands between a cell and the outputs. A wrong bank select shows as a location that reads back its neighbour's data in a full sweep of the address space. A cell that was not updated in multi-port mode shows as two ports that disagree at the same address. Sweeping every address of every mode after a patterned write exposes each such state within one pass.

// File: rtl/lutram_pkg.sv
package lutram_pkg;

    localparam int CELL_AW    = 6;
    localparam int CELL_DEPTH = 1 << CELL_AW;

    typedef enum logic [2:0] {
        ARR_SP64,
        ARR_SP128,
        ARR_SP256,
        ARR_DP,
        ARR_QP,
        ARR_SDP3
    } arr_e;

    // request presented to one storage cell
    typedef struct packed {
        logic               we;
        logic [CELL_AW-1:0] waddr;
        logic               wbit;
        logic [CELL_AW-1:0] raddr;
    } cell_req_t;

    function automatic int arr_cells(arr_e m);
        case (m)
            ARR_SP64:  return 1;
            ARR_SP128: return 2;
            ARR_SP256: return 4;
            ARR_DP:    return 2;
            ARR_QP:    return 4;
            default:   return 3;
        endcase
    endfunction

    function automatic int arr_addr_w(arr_e m);
        case (m)
            ARR_SP128: return CELL_AW + 1;
            ARR_SP256: return CELL_AW + 2;
            default:   return CELL_AW;
        endcase
    endfunction

    function automatic int arr_data_w(arr_e m);
        return (m == ARR_SDP3) ? 3 : 1;
    endfunction

    function automatic int arr_xports(arr_e m);
        case (m)
            ARR_DP:   return 1;
            ARR_QP:   return 3;
            ARR_SDP3: return 1;
            default:  return 0;
        endcase
    endfunction

    function automatic int arr_xw(arr_e m);
        return (arr_xports(m) > 0) ? arr_xports(m) : 1;
    endfunction

    function automatic bit arr_banked(arr_e m);
        return (m == ARR_SP64) || (m == ARR_SP128) || (m == ARR_SP256);
    endfunction

    function automatic bit arr_shared(arr_e m);
        return (m == ARR_DP) || (m == ARR_QP);
    endfunction

endpackage

// File: rtl/lutram_cell.sv
module lutram_cell
    import lutram_pkg::*;
(
    input  logic      clk,
    input  cell_req_t req,
    output logic      q
);
    logic [CELL_DEPTH-1:0] mem = '0;
    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        armed <= 1'b1;
        if (req.we) begin
            mem[req.waddr] <= req.wbit;
        end
    end

    assign q = mem[req.raddr];

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!armed)
        req.we |=> (mem[$past(req.waddr)] == $past(req.wbit)));

    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!armed)
        !req.we |=> $stable(mem));

endmodule

// File: rtl/lutram_steer.sv
module lutram_steer
    import lutram_pkg::*;
#(
    parameter arr_e MODE = ARR_SP64,
    localparam int NC = arr_cells(MODE),
    localparam int AW = arr_addr_w(MODE),
    localparam int DW = arr_data_w(MODE),
    localparam int XW = arr_xw(MODE)
) (
    input  logic                    wr_en,
    input  logic [AW-1:0]           rw_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [XW*CELL_AW-1:0]   ra_addr,
    output cell_req_t [NC-1:0]      req
);
    localparam int SELW = (AW > CELL_AW) ? AW - CELL_AW : 1;

    logic [SELW-1:0] sel;

    generate
        if (AW > CELL_AW) begin : g_sel
            assign sel = rw_addr[AW-1:CELL_AW];
        end else begin : g_nosel
            assign sel = '0;
        end

        if (arr_banked(MODE)) begin : g_unused
            logic unused_ra;
            assign unused_ra = ^ra_addr;
        end

        for (genvar i = 0; i < NC; i++) begin : g_cell
            if (arr_banked(MODE)) begin : g_bank
                assign req[i] = '{we:    wr_en && (sel == SELW'(i)),
                                  waddr: rw_addr[CELL_AW-1:0],
                                  wbit:  wr_data[0],
                                  raddr: rw_addr[CELL_AW-1:0]};
            end else if (MODE == ARR_SDP3) begin : g_slice
                assign req[i] = '{we:    wr_en,
                                  waddr: rw_addr[CELL_AW-1:0],
                                  wbit:  wr_data[i],
                                  raddr: ra_addr[CELL_AW-1:0]};
            end else if (i == 0) begin : g_port_a
                assign req[i] = '{we:    wr_en,
                                  waddr: rw_addr[CELL_AW-1:0],
                                  wbit:  wr_data[0],
                                  raddr: rw_addr[CELL_AW-1:0]};
            end else begin : g_port_x
                assign req[i] = '{we:    wr_en,
                                  waddr: rw_addr[CELL_AW-1:0],
                                  wbit:  wr_data[0],
                                  raddr: ra_addr[(i-1)*CELL_AW +: CELL_AW]};
            end
        end
    endgenerate

endmodule

// File: rtl/lutram_rdmux.sv
module lutram_rdmux
    import lutram_pkg::*;
#(
    parameter arr_e MODE = ARR_SP64,
    localparam int NC = arr_cells(MODE),
    localparam int AW = arr_addr_w(MODE),
    localparam int DW = arr_data_w(MODE),
    localparam int XW = arr_xw(MODE)
) (
    input  logic [NC-1:0]    cell_q,
    input  logic [AW-1:0]    rw_addr,
    output logic [DW-1:0]    a_rdata,
    output logic [XW*DW-1:0] x_rdata
);
    generate
        if (arr_banked(MODE) && (NC > 1)) begin : g_deep
            logic unused_lo;
            assign unused_lo = ^rw_addr[CELL_AW-1:0];
            assign a_rdata   = cell_q[rw_addr[AW-1:CELL_AW]];
            assign x_rdata   = '0;
        end else begin : g_flat
            logic unused_rw;
            assign unused_rw = ^rw_addr;
            if (arr_banked(MODE)) begin : g_sp64
                assign a_rdata = cell_q[0];
                assign x_rdata = '0;
            end else if (MODE == ARR_SDP3) begin : g_wide
                assign a_rdata = '0;
                assign x_rdata = cell_q;
            end else begin : g_multi
                assign a_rdata = cell_q[0];
                assign x_rdata = cell_q[NC-1:1];
            end
        end
    endgenerate

endmodule

// File: rtl/lutram_multiport.sv
module lutram_multiport
    import lutram_pkg::*;
#(
    parameter arr_e MODE = ARR_SP256,
    localparam int NC = arr_cells(MODE),
    localparam int AW = arr_addr_w(MODE),
    localparam int DW = arr_data_w(MODE),
    localparam int XW = arr_xw(MODE)
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [AW-1:0]         rw_addr,
    input  logic [DW-1:0]         wr_data,
    input  logic [XW*CELL_AW-1:0] ra_addr,
    output logic [DW-1:0]         a_rdata,
    output logic [XW*DW-1:0]      x_rdata
);
    cell_req_t [NC-1:0] req;
    logic [NC-1:0]      cell_q;
    logic [NC-1:0]      cell_we;
    logic               armed = 1'b0;

    always_ff @(posedge clk) armed <= 1'b1;

    lutram_steer #(.MODE(MODE)) u_steer (
        .wr_en   (wr_en),
        .rw_addr (rw_addr),
        .wr_data (wr_data),
        .ra_addr (ra_addr),
        .req     (req)
    );

    generate
        for (genvar i = 0; i < NC; i++) begin : g_cells
            assign cell_we[i] = req[i].we;
            lutram_cell u_cell (
                .clk (clk),
                .req (req[i]),
                .q   (cell_q[i])
            );
        end
    endgenerate

    lutram_rdmux #(.MODE(MODE)) u_rdmux (
        .cell_q  (cell_q),
        .rw_addr (rw_addr),
        .a_rdata (a_rdata),
        .x_rdata (x_rdata)
    );

    generate
        if (arr_banked(MODE)) begin : g_chk_bank
            a_r5_one_bank: assert property (@(posedge clk) disable iff (!armed)
                wr_en |-> ($countones(cell_we) == 1));
            a_r5_no_stray: assert property (@(posedge clk) disable iff (!armed)
                !wr_en |-> (cell_we == '0));
        end
        if (arr_shared(MODE)) begin : g_chk_share
            a_r6_broadcast: assert property (@(posedge clk) disable iff (!armed)
                wr_en |-> (&cell_we));
            // R6 and R7: a read-only port at port A's address agrees with it
            for (genvar k = 0; k < XW; k++) begin : g_agree
                a_r7_ports_agree: assert property (@(posedge clk) disable iff (!armed)
                    (ra_addr[k*CELL_AW +: CELL_AW] == rw_addr[CELL_AW-1:0])
                    |-> (x_rdata[k] == a_rdata[0]));
            end
        end
    endgenerate

endmodule

// File: tb/sim_lutram_multiport.sv
module sim_lutram_multiport;
    import lutram_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    // u0: 256x1 single port
    logic w0 = 0; logic [7:0] a0 = 0; logic [0:0] d0 = 0; logic [5:0] ra0 = 0;
    logic [0:0] qa0, qx0;
    // u1: 64x1 quad port
    logic w1 = 0; logic [5:0] a1 = 0; logic [0:0] d1 = 0; logic [17:0] ra1 = 0;
    logic [0:0] qa1; logic [2:0] qx1;
    // u2: 64x3 simple dual port
    logic w2 = 0; logic [5:0] a2 = 0; logic [2:0] d2 = 0; logic [5:0] ra2 = 0;
    logic [2:0] qa2, qx2;
    // u3: 64x1 dual port
    logic w3 = 0; logic [5:0] a3 = 0; logic [0:0] d3 = 0; logic [5:0] ra3 = 0;
    logic [0:0] qa3, qx3;

    logic       ref0 [256];
    logic       ref1 [64];
    logic [2:0] ref2 [64];
    logic       ref3 [64];

    lutram_multiport #(.MODE(ARR_SP256)) u0 (.clk(clk), .wr_en(w0), .rw_addr(a0),
        .wr_data(d0), .ra_addr(ra0), .a_rdata(qa0), .x_rdata(qx0));
    lutram_multiport #(.MODE(ARR_QP)) u1 (.clk(clk), .wr_en(w1), .rw_addr(a1),
        .wr_data(d1), .ra_addr(ra1), .a_rdata(qa1), .x_rdata(qx1));
    lutram_multiport #(.MODE(ARR_SDP3)) u2 (.clk(clk), .wr_en(w2), .rw_addr(a2),
        .wr_data(d2), .ra_addr(ra2), .a_rdata(qa2), .x_rdata(qx2));
    lutram_multiport #(.MODE(ARR_DP)) u3 (.clk(clk), .wr_en(w3), .rw_addr(a3),
        .wr_data(d3), .ra_addr(ra3), .a_rdata(qa3), .x_rdata(qx3));

    function automatic logic pbit(int a, int s);
        return logic'(((a * 29 + s * 7) / 3) % 2);
    endfunction

    function automatic logic [2:0] pword(int a, int s);
        return 3'((a * 5 + s * 3) % 8);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        // R1 power-up zero, R9 read-only outputs of single port stay zero
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            a0 = 8'(a); ra0 = 6'(a) ^ 6'h2a;
            a1 = 6'(a); ra1 = {6'(a + 3), 6'(a + 2), 6'(a + 1)};
            a2 = 6'(a); ra2 = 6'(a);
            a3 = 6'(a); ra3 = 6'(63 - a);
            #1;
            chk("R1", 8'(qa0), 8'h0);
            chk("R9", 8'(qx0), 8'h0);
            if (a < 64) begin
                chk("R1", 8'(qa1), 8'h0);
                chk("R1", 8'(qx1), 8'h0);
                chk("R1", 8'(qx2), 8'h0);
                chk("R1", 8'(qa3), 8'h0);
                chk("R1", 8'(qx3), 8'h0);
            end
        end

        // R2 fill every location with a pattern
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            w0 = 1; a0 = 8'(a); d0 = pbit(a, 1); ref0[a] = pbit(a, 1);
            if (a < 64) begin
                w1 = 1; a1 = 6'(a); d1 = pbit(a, 2); ref1[a] = pbit(a, 2);
                w2 = 1; a2 = 6'(a); d2 = pword(a, 1); ref2[a] = pword(a, 1);
                w3 = 1; a3 = 6'(a); d3 = pbit(a, 3); ref3[a] = pbit(a, 3);
            end else begin
                w1 = 0; w2 = 0; w3 = 0;
            end
        end
        @(negedge clk);
        w0 = 0; w1 = 0; w2 = 0; w3 = 0;

        // R2 and R5 read back all 256 entries; R9 ra_addr has no effect
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            a0 = 8'(a); ra0 = 6'(a * 7);
            #1;
            chk("R5", 8'(qa0), 8'(ref0[a]));
            chk("R9", 8'(qx0), 8'h0);
        end

        // R6, R7, R8 multi-port readback at several address offsets
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            a1  = 6'(a);
            ra1 = {6'(a + 40), 6'(a + 17), 6'(a + 1)};
            a2  = 6'(63 - a); ra2 = 6'(a);
            a3  = 6'(a); ra3 = 6'(63 - a);
            #1;
            chk("R2", 8'(qa1), 8'(ref1[a]));
            chk("R7", 8'(qx1[0]), 8'(ref1[(a + 1) % 64]));
            chk("R7", 8'(qx1[1]), 8'(ref1[(a + 17) % 64]));
            chk("R7", 8'(qx1[2]), 8'(ref1[(a + 40) % 64]));
            chk("R8", 8'(qx2), 8'(ref2[a]));
            chk("R8", 8'(qa2), 8'h0);
            chk("R6", 8'(qa3), 8'(ref3[a]));
            chk("R6", 8'(qx3), 8'(ref3[63 - a]));
        end

        // R3 write enable low: inverted data must not land
        for (int a = 0; a < 256; a += 9) begin
            @(negedge clk);
            w0 = 0; a0 = 8'(a); d0 = ~ref0[a];
            w2 = 0; a2 = 6'(a % 64); d2 = ~ref2[a % 64]; ra2 = 6'(a % 64);
            @(posedge clk);
            #1;
            chk("R3", 8'(qa0), 8'(ref0[a]));
            chk("R3", 8'(qx2), 8'(ref2[a % 64]));
        end

        // R4 read during write: old before the edge, new after it
        for (int a = 5; a < 256; a += 50) begin
            @(negedge clk);
            w0 = 1; a0 = 8'(a); d0 = ~ref0[a];
            w2 = 1; a2 = 6'(a % 64); ra2 = 6'(a % 64); d2 = ~ref2[a % 64];
            w1 = 1; a1 = 6'(a % 64); d1 = ~ref1[a % 64]; ra1 = {3{6'(a % 64)}};
            #1;
            chk("R4", 8'(qa0), 8'(ref0[a]));
            chk("R4", 8'(qx2), 8'(ref2[a % 64]));
            chk("R4", 8'(qx1), 8'({3{ref1[a % 64]}}));
            @(posedge clk);
            #1;
            ref0[a] = ~ref0[a]; ref2[a % 64] = ~ref2[a % 64]; ref1[a % 64] = ~ref1[a % 64];
            chk("R4", 8'(qa0), 8'(ref0[a]));
            chk("R4", 8'(qx2), 8'(ref2[a % 64]));
            chk("R7", 8'(qx1), 8'({3{ref1[a % 64]}}));
            @(negedge clk);
            w0 = 0; w1 = 0; w2 = 0;
        end

        // R2 neighbours of the rewritten entries are untouched; R5 bank aliasing
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            a0 = 8'(a);
            #1;
            chk("R5", 8'(qa0), 8'(ref0[a]));
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule